// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a single-rank SDR SDRAM from power-up to the point where a memory controller may start normal traffic. It waits in an idle state with the device deselected. After a start request it fills a settling interval with no-operation commands, precharges every bank at once, issues a fixed train of auto-refresh commands, and loads the device mode register with one fixed mode word. After that it raises a controller-enable flag that stays set until reset.

Each wait between commands is filled with no-operation commands and timed by a down-counter that is loaded from a parameter. The mode word is fixed to CAS latency 3, interleaved bursts and a burst length of 4, the only setup the attached controller supports. The controller-enable output rises only as the last step, after the final mode-load wait. A start request that arrives while the sequence runs, or after it has finished, is ignored.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is held, and in the idle state after it, the outputs show deselect: cs_n_o=1, ras_n_o=cas_n_o=we_n_o=1. busy_o and ctrl_en_o are both 0.
- R2: When start_i is sampled high in idle, busy_o is high in the next cycle. The first STAB_CYCLES cycles of the sequence carry NOP commands (cs_n_o=0, ras_n_o=cas_n_o=we_n_o=1), and the precharge-all appears in cycle STAB_CYCLES+1.
- R3: The first active command is precharge-all: cs_n_o=0, ras_n_o=0, cas_n_o=1, we_n_o=0, with addr_o[10]=1. It is issued exactly once per sequence.
- R4: The first auto-refresh comes exactly T_RP cycles (default 3) after the precharge-all.
- R5: Exactly REFRESH_COUNT (default 8) auto-refresh commands follow the precharge. Each has cs_n_o=0, ras_n_o=0, cas_n_o=0 and we_n_o=1.
- R6: Each auto-refresh after the first, and the mode-register load, comes exactly T_RC cycles (default 8) after the command before it.
- R7: The mode-register load has cs_n_o=ras_n_o=cas_n_o=we_n_o=0 and ba_o=0. addr_o carries the mode word 0x3A: bits 6..4 hold CAS latency 3 (011), bit 3 is 1 for interleaved bursts, bits 2..0 are 010 for a burst of 4, and all higher bits are 0.
- R8: ctrl_en_o rises exactly T_MRD cycles (default 2) after the mode-register load, never earlier, and stays high until reset.
- R9: Every cycle of the sequence that carries no active command carries a NOP.
- R10: A start_i pulse while busy_o or ctrl_en_o is high has no effect: the command stream and its timing are unchanged, and after completion no further active command appears.
- R11: busy_o and ctrl_en_o are never high together. busy_o falls in the same cycle that ctrl_en_o rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to begin initialization (sampled in idle only) |
| cs_n_o | output | 1 | SDRAM chip select, active low |
| ras_n_o | output | 1 | SDRAM row strobe, active low |
| cas_n_o | output | 1 | SDRAM column strobe, active low |
| we_n_o | output | 1 | SDRAM write enable, active low |
| ba_o | output | BANK_W | Bank select bits |
| addr_o | output | ADDR_W | SDRAM address bus A13..A0 |
| busy_o | output | 1 | Sequence in progress |
| ctrl_en_o | output | 1 | Controller enable, set after the sequence completes |

## Verification
The assertions assume that reset is held for at least one clock edge before the first start request, and that start_i is a plain level with no timing relation to the sequence. They also assume that every wait parameter is at least 2, so each wait interval holds at least one NOP. The stimulus keeps within these assumptions. Each run opens with a reset. Start pulses land at random points: during the settling interval, between refreshes and after completion. One run drops reset in the middle of the refresh train to check the return to idle.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [2:0] {
    CMD_DESEL,
    CMD_NOP,
    CMD_PRE_ALL,
    CMD_REFRESH,
    CMD_LOAD_MODE
  } init_cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_STAB,
    ST_PRE,
    ST_WAIT_RP,
    ST_REF,
    ST_WAIT_RC,
    ST_MRS,
    ST_WAIT_MRD,
    ST_READY
  } init_state_e;

  // Mode word: CAS latency in [6:4], interleaved burst flag in [3], burst-of-4 code in [2:0]
  function automatic logic [15:0] mode_word(input logic [2:0] cas_lat);
    logic [15:0] m;
    m      = '0;
    m[6:4] = cas_lat;
    m[3]   = 1'b1;
    m[2:0] = 3'b010;
    return m;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdr_init_timer.sv
module sdr_init_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last_o = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/sdr_init_ref_ctr.sv
module sdr_init_ref_ctr #(
  parameter int unsigned REF_N = 8,
  localparam int unsigned W    = $clog2(REF_N + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic inc_i,
  output logic all_done_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      cnt_q <= '0;
    end else if (inc_i && (cnt_q != W'(REF_N))) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign all_done_o = (cnt_q == W'(REF_N));

endmodule

// File: rtl/sdr_init_cmd_enc.sv
module sdr_init_cmd_enc
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W  = 14,
  parameter int unsigned BANK_W  = 2,
  parameter int unsigned CAS_LAT = 3
) (
  input  init_cmd_e         cmd_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ADDR_W-1:0] addr_o
);

  localparam logic [15:0] MODE_FULL = mode_word(3'(CAS_LAT));

  always_comb begin
    cs_n_o  = 1'b0;
    ras_n_o = 1'b1;
    cas_n_o = 1'b1;
    we_n_o  = 1'b1;
    ba_o    = '0;
    addr_o  = '0;
    unique case (cmd_i)
      CMD_DESEL: cs_n_o = 1'b1;
      CMD_NOP:   ;
      CMD_PRE_ALL: begin
        ras_n_o    = 1'b0;
        we_n_o     = 1'b0;
        addr_o[10] = 1'b1;
      end
      CMD_REFRESH: begin
        ras_n_o = 1'b0;
        cas_n_o = 1'b0;
      end
      CMD_LOAD_MODE: begin
        ras_n_o = 1'b0;
        cas_n_o = 1'b0;
        we_n_o  = 1'b0;
        addr_o  = MODE_FULL[ADDR_W-1:0];
      end
      default: cs_n_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned STAB_CYCLES   = 20,
  parameter int unsigned T_RP          = 3,
  parameter int unsigned T_RC          = 8,
  parameter int unsigned T_MRD         = 2,
  parameter int unsigned REFRESH_COUNT = 8,
  parameter int unsigned CAS_LAT       = 3,
  parameter int unsigned ADDR_W        = 14,
  parameter int unsigned BANK_W        = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              busy_o,
  output logic              ctrl_en_o
);

  localparam int unsigned WAIT_MAX = max2(max2(STAB_CYCLES, T_RP), max2(T_RC, T_MRD));
  localparam int unsigned CNT_W    = $clog2(WAIT_MAX + 1);

  init_state_e      state_q, state_d;
  init_cmd_e        cmd_kind;
  logic             timer_load;
  logic [CNT_W-1:0] timer_val;
  logic             timer_last;
  logic             refs_all;
  logic             ref_issue;
  logic             start_accept;

  assign start_accept = start_i && (state_q == ST_IDLE);
  assign ref_issue    = (state_q == ST_REF);

  always_comb begin
    state_d    = state_q;
    timer_load = 1'b0;
    timer_val  = '0;
    unique case (state_q)
      ST_IDLE: if (start_accept) begin
        state_d    = ST_STAB;
        timer_load = 1'b1;
        timer_val  = CNT_W'(STAB_CYCLES);
      end
      ST_STAB:    if (timer_last) state_d = ST_PRE;
      ST_PRE: begin
        state_d    = ST_WAIT_RP;
        timer_load = 1'b1;
        timer_val  = CNT_W'(T_RP - 1);
      end
      ST_WAIT_RP: if (timer_last) state_d = ST_REF;
      ST_REF: begin
        state_d    = ST_WAIT_RC;
        timer_load = 1'b1;
        timer_val  = CNT_W'(T_RC - 1);
      end
      ST_WAIT_RC: if (timer_last) state_d = refs_all ? ST_MRS : ST_REF;
      ST_MRS: begin
        state_d    = ST_WAIT_MRD;
        timer_load = 1'b1;
        timer_val  = CNT_W'(T_MRD - 1);
      end
      ST_WAIT_MRD: if (timer_last) state_d = ST_READY;
      ST_READY:    state_d = ST_READY;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    unique case (state_q)
      ST_IDLE:  cmd_kind = CMD_DESEL;
      ST_PRE:   cmd_kind = CMD_PRE_ALL;
      ST_REF:   cmd_kind = CMD_REFRESH;
      ST_MRS:   cmd_kind = CMD_LOAD_MODE;
      default:  cmd_kind = CMD_NOP;
    endcase
  end

  sdr_init_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (timer_load),
    .load_val_i (timer_val),
    .last_o     (timer_last)
  );

  sdr_init_ref_ctr #(.REF_N(REFRESH_COUNT)) u_ref_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (state_q == ST_IDLE),
    .inc_i      (ref_issue),
    .all_done_o (refs_all)
  );

  sdr_init_cmd_enc #(
    .ADDR_W  (ADDR_W),
    .BANK_W  (BANK_W),
    .CAS_LAT (CAS_LAT)
  ) u_enc (
    .cmd_i   (cmd_kind),
    .cs_n_o  (cs_n_o),
    .ras_n_o (ras_n_o),
    .cas_n_o (cas_n_o),
    .we_n_o  (we_n_o),
    .ba_o    (ba_o),
    .addr_o  (addr_o)
  );

  assign busy_o    = (state_q != ST_IDLE) && (state_q != ST_READY);
  assign ctrl_en_o = (state_q == ST_READY);

endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
  parameter int unsigned T_RP          = 3,
  parameter int unsigned T_RC          = 8,
  parameter int unsigned T_MRD         = 2,
  parameter int unsigned REFRESH_COUNT = 8,
  parameter int unsigned CAS_LAT       = 3,
  parameter int unsigned ADDR_W        = 14,
  parameter int unsigned BANK_W        = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              cs_n_o,
  input logic              ras_n_o,
  input logic              cas_n_o,
  input logic              we_n_o,
  input logic [BANK_W-1:0] ba_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              busy_o,
  input logic              ctrl_en_o
);

  logic is_pre, is_ref, is_mrs, is_nop, is_active;
  assign is_nop    = !cs_n_o && ras_n_o && cas_n_o && we_n_o;
  assign is_pre    = !cs_n_o && !ras_n_o && cas_n_o && !we_n_o;
  assign is_ref    = !cs_n_o && !ras_n_o && !cas_n_o && we_n_o;
  assign is_mrs    = !cs_n_o && !ras_n_o && !cas_n_o && !we_n_o;
  assign is_active = is_pre || is_ref || is_mrs;

  logic [15:0] since_cmd;
  logic [15:0] since_mrs;
  logic [7:0]  refs_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_cmd <= '0;
      since_mrs <= '0;
      refs_seen <= '0;
    end else begin
      if (is_active)               since_cmd <= 16'd1;
      else if (since_cmd != '1)    since_cmd <= since_cmd + 16'd1;
      if (is_mrs)                  since_mrs <= 16'd1;
      else if (since_mrs != '1)    since_mrs <= since_mrs + 16'd1;
      if (!busy_o && !ctrl_en_o)   refs_seen <= '0;
      else if (is_ref)             refs_seen <= refs_seen + 8'd1;
    end
  end

  a_r1_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !ctrl_en_o) |-> (cs_n_o && ras_n_o && cas_n_o && we_n_o));

  a_r2_start_begins: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !ctrl_en_o) |=> busy_o);

  a_r3_pre_a10: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> (addr_o[10] && refs_seen == 8'd0));

  a_r4_first_ref_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ref && refs_seen == 8'd0) |-> (since_cmd == 16'(T_RP)));

  a_r6_ref_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ref && refs_seen != 8'd0) |-> (since_cmd == 16'(T_RC)));

  a_r5_ref_count: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> (refs_seen == 8'(REFRESH_COUNT) && since_cmd == 16'(T_RC)));

  a_r7_mode_word: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> (ba_o == '0 && addr_o[6:4] == 3'(CAS_LAT) && addr_o[3] &&
                addr_o[2:0] == 3'b010 && (addr_o >> 7) == '0));

  a_r8_enable_after_mrs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_en_o) |-> (since_mrs == 16'(T_MRD)));

  a_r8_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_en_o |=> ctrl_en_o);

  a_r9_wait_nop: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !is_active) |-> is_nop);

  a_r10_start_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en_o && start_i) |=> (ctrl_en_o && !busy_o && !is_active));

  a_r11_busy_en_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && ctrl_en_o));

endmodule

bind sdram_init_seq sdram_init_chk #(
  .T_RP          (T_RP),
  .T_RC          (T_RC),
  .T_MRD         (T_MRD),
  .REFRESH_COUNT (REFRESH_COUNT),
  .CAS_LAT       (CAS_LAT),
  .ADDR_W        (ADDR_W),
  .BANK_W        (BANK_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .cs_n_o    (cs_n_o),
  .ras_n_o   (ras_n_o),
  .cas_n_o   (cas_n_o),
  .we_n_o    (we_n_o),
  .ba_o      (ba_o),
  .addr_o    (addr_o),
  .busy_o    (busy_o),
  .ctrl_en_o (ctrl_en_o)
);

// File: tb/test_sdram_init_seq.sv
module test_sdram_init_seq;

  localparam int P_STAB = 20;
  localparam int P_RP   = 3;
  localparam int P_RC   = 8;
  localparam int P_MRD  = 2;
  localparam int P_REFS = 8;
  localparam int P_CL   = 3;
  localparam int SEQ_LEN = P_STAB + P_RP + P_REFS * P_RC + P_MRD;

  // bench command codes
  localparam int K_DESEL = 0, K_NOP = 1, K_PRE = 2, K_REF = 3, K_MRS = 4, K_BAD = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        cs_n_o, ras_n_o, cas_n_o, we_n_o;
  logic [1:0]  ba_o;
  logic [13:0] addr_o;
  logic        busy_o, ctrl_en_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sdram_init_seq #(
    .STAB_CYCLES   (P_STAB),
    .T_RP          (P_RP),
    .T_RC          (P_RC),
    .T_MRD         (P_MRD),
    .REFRESH_COUNT (P_REFS),
    .CAS_LAT       (P_CL),
    .ADDR_W        (14),
    .BANK_W        (2)
  ) i_sdram_init_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .cs_n_o    (cs_n_o),
    .ras_n_o   (ras_n_o),
    .cas_n_o   (cas_n_o),
    .we_n_o    (we_n_o),
    .ba_o      (ba_o),
    .addr_o    (addr_o),
    .busy_o    (busy_o),
    .ctrl_en_o (ctrl_en_o)
  );

  function automatic int exp_mode(input int cl);
    return ((cl & 7) << 4) | (1 << 3) | 2;
  endfunction

  function automatic int decode(input logic cs, input logic r, input logic c, input logic w);
    if (cs) return K_DESEL;
    case ({r, c, w})
      3'b111:  return K_NOP;
      3'b010:  return K_PRE;
      3'b001:  return K_REF;
      3'b000:  return K_MRS;
      default: return K_BAD;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n   = 1'b0;
    start_i = 1'b0;
    repeat (2) @(negedge clk);
    // R1: outputs while in reset
    check(decode(cs_n_o, ras_n_o, cas_n_o, we_n_o) == K_DESEL, "R1", "deselect in reset",
          decode(cs_n_o, ras_n_o, cas_n_o, we_n_o), K_DESEL);
    check(!busy_o && !ctrl_en_o, "R1", "busy/en in reset", {busy_o, ctrl_en_o}, 0);
    rst_n = 1'b1;
  endtask

  task automatic run_sequence(input bit spurious);
    int kinds[16];
    int cycs[16];
    int addrs[16];
    int bas[16];
    int n_act = 0;
    int en_rise = -1;
    int bad_wait = 0;
    int overlap = 0;
    int busy_first = 0;
    int post_act = 0;
    int idle_gap = 1 + ($urandom % 6);
    do_reset();
    repeat (idle_gap) @(negedge clk);
    // R1: idle after reset
    check(cs_n_o && !busy_o && !ctrl_en_o, "R1", "idle after reset", {cs_n_o, busy_o, ctrl_en_o}, 4);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int cyc = 1; cyc <= SEQ_LEN + 40; cyc++) begin
      int k = decode(cs_n_o, ras_n_o, cas_n_o, we_n_o);
      if (cyc == 1) busy_first = busy_o;
      if (busy_o && ctrl_en_o) overlap++;
      if (k == K_PRE || k == K_REF || k == K_MRS || k == K_BAD) begin
        if (ctrl_en_o) post_act++;
        else if (n_act < 16) begin
          kinds[n_act] = k; cycs[n_act] = cyc; addrs[n_act] = int'(addr_o); bas[n_act] = int'(ba_o);
          n_act++;
        end
      end else if (busy_o && k != K_NOP) begin
        bad_wait++;
      end
      if (ctrl_en_o && en_rise < 0) en_rise = cyc;
      if (en_rise >= 0 && !ctrl_en_o) overlap++;
      start_i = spurious && (($urandom % 5) == 0);
      @(negedge clk);
    end
    start_i = 1'b0;
    check(busy_first == 1, "R2", "busy after start", busy_first, 1);
    check(n_act == P_REFS + 2, "R5", "active command count", n_act, P_REFS + 2);
    if (n_act == P_REFS + 2) begin
      check(kinds[0] == K_PRE, "R3", "first command kind", kinds[0], K_PRE);
      check(cycs[0] == P_STAB + 1, "R2", "precharge cycle", cycs[0], P_STAB + 1);
      check(((addrs[0] >> 10) & 1) == 1, "R3", "precharge A10", (addrs[0] >> 10) & 1, 1);
      check(cycs[1] - cycs[0] == P_RP, "R4", "precharge to refresh gap", cycs[1] - cycs[0], P_RP);
      for (int i = 1; i <= P_REFS; i++) begin
        check(kinds[i] == K_REF, "R5", "refresh kind", kinds[i], K_REF);
        if (i > 1)
          check(cycs[i] - cycs[i-1] == P_RC, "R6", "refresh gap", cycs[i] - cycs[i-1], P_RC);
      end
      check(kinds[P_REFS+1] == K_MRS, "R7", "last command kind", kinds[P_REFS+1], K_MRS);
      check(cycs[P_REFS+1] - cycs[P_REFS] == P_RC, "R6", "refresh to mode gap",
            cycs[P_REFS+1] - cycs[P_REFS], P_RC);
      check(addrs[P_REFS+1] == exp_mode(P_CL), "R7", "mode word", addrs[P_REFS+1], exp_mode(P_CL));
      check(bas[P_REFS+1] == 0, "R7", "mode bank", bas[P_REFS+1], 0);
      check(en_rise == cycs[P_REFS+1] + P_MRD, "R8", "enable rise cycle", en_rise,
            cycs[P_REFS+1] + P_MRD);
    end
    check(bad_wait == 0, "R9", "non-NOP wait cycles", bad_wait, 0);
    check(overlap == 0, "R11", "busy/enable overlap or enable drop", overlap, 0);
    check(post_act == 0, "R10", "commands after completion", post_act, 0);
    check(ctrl_en_o == 1'b1, "R8", "enable held", ctrl_en_o, 1);
  endtask

  task automatic run_abort();
    int stop_at = P_STAB + 10 + ($urandom % 30);
    do_reset();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (stop_at) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(cs_n_o && !busy_o && !ctrl_en_o, "R1", "reset mid-sequence", {cs_n_o, busy_o, ctrl_en_o}, 4);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(cs_n_o && !busy_o && !ctrl_en_o, "R1", "idle after abort", {cs_n_o, busy_o, ctrl_en_o}, 4);
  endtask

  initial begin
    void'($urandom(32'd4242));
    run_sequence(1'b0);
    run_sequence(1'b1);
    run_abort();
    run_sequence(1'b1);
    run_sequence(1'b1);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule